// File: doc/BRIEF.md
# Byte-Serial Fraction Multiplier

This block multiplies two 56-bit fractions by walking through the multiplier one byte per clock. The multiplicand is sanitised on entry: its sign and exponent positions are forced to zero and the implied leading one is placed just above the 47 stored fraction bits. In each step the sanitised multiplicand is multiplied by the current multiplier byte, using a radix-4 signed-digit recoding of that byte. The result is added to a 64-bit accumulator, and the sum is written back eight places to the right.

The accumulator has two parts: a 56-bit data register and an 8-bit guard register below it. Both are cleared whenever a new operation is accepted. The byte shifted out of the bottom in each step appears on a side output with a valid strobe, so that a wider multiply built around this block can collect it. After seven steps the accumulator holds the upper half of the 112-bit product. A one-cycle done pulse marks the end, and the accumulator value is then held until the next accepted start.

Top module: `byte_serial_mul`

## Requirements
- R1: While reset is low at a clock edge, busy, done and lsb_valid go low and prod_out goes to zero.
- R2: The multiplicand used is mcand_in with bits 55..48 cleared and bit 47 set; bits 46..0 pass unchanged.
- R3: A start seen while idle is accepted: in the next cycle busy is high and prod_out reads zero.
- R4: After an accepted start, lsb_valid is high in cycles 2 to 8 and low otherwise. In the k-th of those cycles (k = 0..6), lsb_byte equals bits [8k+7:8k] of the full 112-bit product of the masked multiplicand and mplier_in.
- R5: done is high for exactly one cycle, 8 cycles after the accepted start. In that cycle prod_out equals product bits [111:56], zero-extended to 64 bits.
- R6: busy stays high for exactly 7 consecutive cycles per operation.
- R7: A start asserted while busy is ignored. The running operation completes with its original operands, and no extra operation follows.
- R8: While idle and with no start, prod_out keeps the last result and lsb_valid stays low.
- R9: A start asserted in the same cycle as done is accepted, and the two operations run back to back with no idle cycle between them.
- R10: Every multiplier byte value from 0x00 to 0xFF contributes exactly its unsigned value, including bytes with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a new multiply (taken only while idle) |
| mcand_in | input | 56 | Raw multiplicand word, masked on load |
| mplier_in | input | 56 | Multiplier, consumed low byte first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the last step |
| prod_out | output | 64 | Accumulator (data and guard parts) |
| lsb_valid | output | 1 | lsb_byte carries a byte shifted out this step |
| lsb_byte | output | 8 | Low byte dropped by the latest step |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle. The driver provokes this by raising start in the very cycle it sees done. That cycle's prod_out must still carry the finished upper half, and the following cycle must show busy with a cleared accumulator. The scoreboard then holds the queued low bytes and upper half of both operations, so any lost, repeated or merged step shows up as a byte mismatch. A start raised in the middle of a run is also checked: the original result must come out unchanged and no further bytes may appear.

// File: rtl/bsm_pkg.sv
// Shared constants and types for the byte-serial multiplier.
// Assumes the fraction format: 1 sign bit and 8 exponent bits sit above
// 47 stored fraction bits inside a 56-bit word.
package bsm_pkg;
    localparam int FRAC_W  = 56;  // multiplicand and multiplier width
    localparam int DIGIT_W = 8;   // multiplier bits consumed per step
    localparam int GUARD_W = 8;   // guard bits below the data register
    localparam int HEAD_W  = 9;   // sign plus exponent bits to clear

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bsm_state_e;
endpackage

// File: rtl/bsm_operand_mask.sv
// Clears the sign and exponent positions of a raw operand word and
// sets the implied leading one just above the stored fraction.
// Assumes HEAD_W >= 2, so the hidden bit lands inside the cleared field.
module bsm_operand_mask #(
    parameter int W      = 56,
    parameter int HEAD_W = 9
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] masked
);
    localparam int FR_W = W - HEAD_W;
    localparam logic [W-1:0] KEEP   = {{HEAD_W{1'b0}}, {FR_W{1'b1}}};
    localparam logic [W-1:0] HIDDEN = W'(1) << FR_W;

    // Keep fraction bits, force the head field to the hidden-one pattern
    assign masked = (raw & KEEP) | HIDDEN;
endmodule

// File: rtl/bsm_booth_row.sv
// Multiplies an unsigned MW-bit multiplicand by one unsigned DW-bit
// multiplier digit. The digit is zero-extended and recoded into
// radix-4 signed digits in {-2..+2}. Arithmetic is modulo 2^(MW+DW),
// which is exact because the true product always fits.
// Assumes DW is even.
module bsm_booth_row #(
    parameter int MW = 56,
    parameter int DW = 8
) (
    input  logic [MW-1:0]    md,
    input  logic [DW-1:0]    digit,
    output logic [MW+DW-1:0] prod
);
    localparam int NDIG  = DW / 2 + 1;
    localparam int EXT_W = 2 * NDIG + 1;
    localparam int PW    = MW + DW;

    logic [EXT_W-1:0] ext;
    logic [PW-1:0]    md_x;
    logic [PW-1:0]    term [NDIG];

    // Zero-extend the digit and append the implicit bit below it
    assign ext  = {{(EXT_W-DW-1){1'b0}}, digit, 1'b0};
    assign md_x = PW'(md);

    genvar k;
    generate
        for (k = 0; k < NDIG; k++) begin : g_dig
            logic [2:0]    sel3;
            logic          neg, one, two;
            logic [PW-1:0] mag;

            assign sel3 = ext[2*k+2 : 2*k];

            // Decode one overlapping bit triple into sign and magnitude
            always_comb begin
                neg = 1'b0;
                one = 1'b0;
                two = 1'b0;
                case (sel3)
                    3'b001, 3'b010: one = 1'b1;
                    3'b011:         two = 1'b1;
                    3'b100: begin neg = 1'b1; two = 1'b1; end
                    3'b101, 3'b110: begin neg = 1'b1; one = 1'b1; end
                    default: ;
                endcase
            end

            // Select the multiple, negate if needed, align to its weight
            assign mag     = one ? md_x : (two ? (md_x << 1) : '0);
            assign term[k] = (neg ? (~mag + PW'(1)) : mag) << (2 * k);
        end
    endgenerate

    // Add the recoded partial products
    always_comb begin
        prod = '0;
        for (int i = 0; i < NDIG; i++) begin
            prod = prod + term[i];
        end
    end
endmodule

// File: rtl/bsm_sequencer.sv
// Control for one multiply. A start is taken only while idle. Exactly
// NSTEP step cycles follow, and done pulses for one cycle after the last.
// Assumes NSTEP >= 1.
module bsm_sequencer
    import bsm_pkg::*;
#(
    parameter int NSTEP = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load_en,
    output logic step_en
);
    localparam int CNT_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NSTEP - 1);

    bsm_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             last_step;

    assign busy      = (state == ST_RUN);
    assign load_en   = start && (state == ST_IDLE);
    assign step_en   = (state == ST_RUN);
    assign last_step = step_en && (cnt == LAST);

    // State, step counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= last_step;
            if (load_en) begin
                state <= ST_RUN;
                cnt   <= '0;
            end else if (last_step) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else if (step_en) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/bsm_accum.sv
// Accumulator made of a data register above a guard register. Each step
// adds the incoming row product and writes the sum back DW places to the
// right. The byte shifted out is registered on the side output.
// Assumes the sum never exceeds ACC_W bits, which holds when the row
// product is at most ACC_W bits wide and DW <= GUARD_W.
module bsm_accum #(
    parameter int ACC_W   = 64,
    parameter int GUARD_W = 8,
    parameter int DW      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [ACC_W-1:0] row,
    output logic [ACC_W-1:0] acc,
    output logic             lsb_valid,
    output logic [DW-1:0]    lsb_byte
);
    localparam int DATA_W = ACC_W - GUARD_W;

    logic [DATA_W-1:0]  data_q;
    logic [GUARD_W-1:0] guard_q;
    logic [ACC_W-1:0]   sum;
    logic [ACC_W-1:0]   shifted;

    assign acc     = {data_q, guard_q};
    assign sum     = acc + row;
    assign shifted = sum >> DW;

    // Clear on load, shift-accumulate on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            guard_q <= '0;
        end else if (clear) begin
            data_q  <= '0;
            guard_q <= '0;
        end else if (step) begin
            data_q  <= shifted[ACC_W-1:GUARD_W];
            guard_q <= shifted[GUARD_W-1:0];
        end
    end

    // Register the dropped low byte and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsb_valid <= 1'b0;
            lsb_byte  <= '0;
        end else begin
            lsb_valid <= step;
            if (step) begin
                lsb_byte <= sum[DW-1:0];
            end
        end
    end
endmodule

// File: rtl/byte_serial_mul.sv
// Top of the byte-serial fraction multiplier. It latches the masked
// multiplicand and the multiplier on an accepted start, then runs one
// recoded byte row per cycle into the accumulator.
// Assumes FRAC_W is a multiple of DIGIT_W and DIGIT_W <= GUARD_W.
module byte_serial_mul
    import bsm_pkg::*;
#(
    parameter int W_FRAC  = FRAC_W,
    parameter int W_DIGIT = DIGIT_W,
    parameter int W_GUARD = GUARD_W,
    parameter int W_HEAD  = HEAD_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [W_FRAC-1:0]          mcand_in,
    input  logic [W_FRAC-1:0]          mplier_in,
    output logic                       busy,
    output logic                       done,
    output logic [W_FRAC+W_GUARD-1:0]  prod_out,
    output logic                       lsb_valid,
    output logic [W_DIGIT-1:0]         lsb_byte
);
    localparam int ACC_W = W_FRAC + W_GUARD;
    localparam int NSTEP = W_FRAC / W_DIGIT;
    localparam int ROW_W = W_FRAC + W_DIGIT;

    logic              load_en, step_en;
    logic [W_FRAC-1:0] md_masked;
    logic [W_FRAC-1:0] md_q;
    logic [W_FRAC-1:0] mq_q;
    logic [ROW_W-1:0]  row_prod;

    bsm_sequencer #(.NSTEP(NSTEP)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .load_en (load_en),
        .step_en (step_en)
    );

    bsm_operand_mask #(.W(W_FRAC), .HEAD_W(W_HEAD)) u_mask (
        .raw    (mcand_in),
        .masked (md_masked)
    );

    // Operand registers: load on accept, shift the multiplier on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md_q <= '0;
            mq_q <= '0;
        end else if (load_en) begin
            md_q <= md_masked;
            mq_q <= mplier_in;
        end else if (step_en) begin
            mq_q <= mq_q >> W_DIGIT;
        end
    end

    bsm_booth_row #(.MW(W_FRAC), .DW(W_DIGIT)) u_row (
        .md    (md_q),
        .digit (mq_q[W_DIGIT-1:0]),
        .prod  (row_prod)
    );

    bsm_accum #(.ACC_W(ACC_W), .GUARD_W(W_GUARD), .DW(W_DIGIT)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load_en),
        .step      (step_en),
        .row       (ACC_W'(row_prod)),
        .acc       (prod_out),
        .lsb_valid (lsb_valid),
        .lsb_byte  (lsb_byte)
    );
endmodule

// File: rtl/byte_serial_mul_chk.sv
// Temporal checks on the multiplier's ports, attached by bind.
// Counts busy cycles with a local counter instead of a long delay.
module byte_serial_mul_chk #(
    parameter int NSTEP = 7,
    parameter int ACC_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             lsb_valid,
    input logic [ACC_W-1:0] prod_out
);
    int run_len;

    // Length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else run_len <= 0;
    end

    // R3
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && prod_out == '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R6
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == NSTEP));

    // R4
    strobe_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsb_valid |-> $past(busy));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prod_out) && !lsb_valid));
endmodule

bind byte_serial_mul byte_serial_mul_chk #(
    .NSTEP (W_FRAC / W_DIGIT),
    .ACC_W (W_FRAC + W_GUARD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .lsb_valid (lsb_valid),
    .prod_out  (prod_out)
);

// File: tb/byte_serial_mul_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected bytes and results; a
// monitor pops and compares them as the outputs appear.
module byte_serial_mul_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [55:0] mcand_in = '0;
    logic [55:0] mplier_in = '0;
    logic        busy, done, lsb_valid;
    logic [63:0] prod_out;
    logic [7:0]  lsb_byte;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    logic [63:0] last_final = '0;
    logic [7:0]  lsb_q [$];
    logic [63:0] fin_q [$];
    int busy_run = 0;

    always #2 clk = ~clk;

    byte_serial_mul uut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .mcand_in (mcand_in), .mplier_in (mplier_in),
        .busy (busy), .done (done), .prod_out (prod_out),
        .lsb_valid (lsb_valid), .lsb_byte (lsb_byte)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R2: masked multiplicand model
    function automatic logic [55:0] mask_of(input logic [55:0] raw);
        return {8'h00, 1'b1, raw[46:0]};
    endfunction

    // Queue the expected outputs of one operation
    task automatic expect_op(input logic [55:0] raw, input logic [55:0] q);
        logic [111:0] p;
        p = 112'(mask_of(raw)) * 112'(q);
        for (int k = 0; k < 7; k++) lsb_q.push_back(p[8*k +: 8]);
        fin_q.push_back(64'(p[111:56]));
        last_final = 64'(p[111:56]);
    endtask

    // Pulse start at a negedge; check acceptance one cycle later (R3)
    task automatic start_op(input logic [55:0] raw, input logic [55:0] q);
        expect_op(raw, q);
        mcand_in  = raw;
        mplier_in = q;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3 busy", 64'(busy), 64'd1);
        chk(prod_out == '0, "R3 cleared", prod_out, 64'd0);
    endtask

    // Wait for the completion pulse
    task automatic wait_done();
        int n = 0;
        bit seen = 1'b0;
        while (!seen && n < 40) begin
            @(negedge clk);
            n++;
            if (done) seen = 1'b1;
        end
        chk(seen, "R5 done seen", 64'(seen), 64'd1);
    endtask

    // Monitor: scoreboard compare and busy run length
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (lsb_valid) begin
                if (lsb_q.size() == 0) chk(1'b0, "R4 unexpected byte", 64'(lsb_byte), 64'd0);
                else begin
                    logic [7:0] e;
                    e = lsb_q.pop_front();
                    chk(lsb_byte == e, "R4 low byte", 64'(lsb_byte), 64'(e));
                end
            end
            if (done) begin
                if (fin_q.size() == 0) chk(1'b0, "R5 unexpected done", prod_out, 64'd0);
                else begin
                    logic [63:0] e;
                    e = fin_q.pop_front();
                    chk(prod_out == e, "R5 upper half", prod_out, e);
                end
            end
            if (busy) busy_run++;
            else if (busy_run != 0) begin
                chk(busy_run == 7, "R6 busy length", 64'(busy_run), 64'd7);
                busy_run = 0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 64'd0, 64'd1);
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [63:0] s;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(lsb_valid == 1'b0, "R1 lsb_valid", 64'(lsb_valid), 64'd0);
        chk(prod_out == '0, "R1 prod_out", prod_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: zero raw word gives the hidden one alone; multiplier 1
        start_op(56'h0, 56'h1);
        wait_done();
        // R2: head bits set in raw must be cleared
        start_op(56'hFF_FFFF_FFFF_FFFF, 56'h12_3456_789A_BCDE);
        wait_done();
        // R10: all-ones multiplier and bytes with bit 7 set
        start_op(56'h01_2345_6789_ABCD, 56'hFF_FFFF_FFFF_FFFF);
        wait_done();
        start_op(56'h7A_5A5A_5A5A_5A5A, 56'h80_807F_7F01_8081);
        wait_done();
        // zero multiplier: every byte and the result are zero
        start_op(56'h33_CCCC_3333_CCCC, 56'h0);
        wait_done();

        // R8: result held while idle
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(prod_out == last_final, "R8 held", prod_out, last_final);
            chk(lsb_valid == 1'b0, "R8 no strobe", 64'(lsb_valid), 64'd0);
        end

        // R7: start raised mid-run is ignored
        start_op(56'h55_0F0F_F0F0_1234, 56'hC3_A5E1_0077_FF80);
        repeat (2) @(negedge clk);
        mcand_in  = 56'hAB_CDEF_0123_4567;
        mplier_in = 56'h11_1111_1111_1111;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 still busy", 64'(busy), 64'd1);
        wait_done();
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R7 no extra run", 64'(busy), 64'd0);

        // R9: back-to-back starts in the done cycle, pseudo-random operands
        s = 64'h9E37_79B9_7F4A_7C15;
        start_op(s[55:0], s[63:8]);
        for (int i = 0; i < 12; i++) begin
            wait_done();
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            start_op(s[55:0], {s[7:0], s[63:16]});
        end
        wait_done();
        repeat (3) @(negedge clk);

        chk(lsb_q.size() == 0, "R4 bytes drained", 64'(lsb_q.size()), 64'd0);
        chk(fin_q.size() == 0, "R5 results drained", 64'(fin_q.size()), 64'd0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule